// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block is a clocked bus master for a byte-wide parallel flash with active-low chip-enable, output-enable and write strobes. A client hands it one request at a time over a valid/ready handshake. A request is a byte program, a sector erase or a whole-array erase. The block drives the unlock write cycles that the chosen operation needs. It then polls the flash status line that flips on every read while an internal operation runs. It reports the result as a single-cycle response with an error flag.

All bus timing comes from the system clock. Strobe widths, hold times and the read access wait are given in nanoseconds together with the clock period, and are turned into cycle counts when the design is elaborated. Completion detection guards against a read that lands while the flash is finishing. A run of equal status reads is needed before the operation counts as finished. If polling runs past a cycle budget, the request ends with an error. Program and erase each have their own budget.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, flash_ce_n, flash_oe_n and flash_we_n are 1, and flash_dq_oe is 0.
- R2: A request with req_op = 0 (program) issues exactly four bus writes, as address/data pairs: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then req_addr/req_data.
- R3: A request with req_op = 1 (sector erase) issues exactly six bus writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, then req_addr/0x30. Bits 17..12 of req_addr pick the sector.
- R4: A request with req_op = 2 (whole-array erase) issues the same first five writes as R3 and then 0x5555/0x10. The upper address bits of every unlock write are zero.
- R5: A request with req_op = 3 causes no bus cycle. resp_valid rises with resp_err = 1 in the cycle after acceptance.
- R6: Each write holds flash_we_n low for at least WE_LOW_NS and for at least DATA_SETUP_NS. Between pulses it stays high for at least WE_HIGH_NS. flash_addr and flash_dq_out stay stable from before the falling strobe until at least ADDR_HOLD_NS after it rises. flash_ce_n is low and flash_oe_n is high across the strobe.
- R7: A status read drives flash_ce_n and flash_oe_n low with flash_we_n high and flash_dq_oe at 0. It samples flash_tog_in no earlier than READ_ACCESS_NS after flash_oe_n falls.
- R8: After the last command write the block reads status repeatedly. Success needs two consecutive reads with equal bit values, followed by CONFIRM_READS (default 2) further reads with that same value. A single equal pair that is followed by a different value does not end the operation. With the defaults, success follows exactly four equal reads in a row.
- R9: The polling budget is PROG_TIMEOUT_CYC cycles for a program and ERASE_TIMEOUT_CYC cycles for either erase. When the budget is exceeded, the block ends polling before the next read, releases the bus and responds with resp_err = 1.
- R10: req_ready falls in the cycle after a request is accepted. It stays low until the cycle after the single-cycle resp_valid pulse. req_valid and the request fields are ignored while req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 whole-array erase, 3 rejected |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Set with resp_valid on timeout or rejected request |
| flash_addr | output | AW | Flash address bus |
| flash_dq_out | output | 8 | Data driven to the flash |
| flash_dq_oe | output | 1 | Enable for flash_dq_out onto the data lines |
| flash_tog_in | input | 1 | Flash status data line that flips while busy |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write strobe, active low |

## Verification
Several properties are checked by assertions on every cycle:
- the strobe is never low without chip enable;
- writes and reads never overlap;
- address and data hold still while the strobe is low;
- a rejected opcode is answered in the next cycle;
- ready only comes back after a response pulse.

Other behaviour can only be shown by the bench's scenarios, using a flash model that flips the status bit on each read for a chosen number of reads and can stall for one read to mimic a race:
- the exact unlock address/data order;
- nanosecond strobe and access widths;
- the exact read count at which completion is declared;
- the separate program and erase budgets.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   localparam int BYTE_W  = 8;
   localparam int SEQ_MAX = 8;

   typedef enum logic [1:0] {
      OP_PROG  = 2'd0,
      OP_SECT  = 2'd1,
      OP_CHIP  = 2'd2,
      OP_BAD   = 2'd3
   } fpc_op_e;

   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_WR      = 3'd1,
      S_WR_WAIT = 3'd2,
      S_RD      = 3'd3,
      S_RD_WAIT = 3'd4
   } fpc_state_e;

   typedef enum logic [2:0] {
      P_IDLE  = 3'd0,
      P_WSET  = 3'd1,
      P_WLOW  = 3'd2,
      P_WHOLD = 3'd3,
      P_RACC  = 3'd4,
      P_RGAP  = 3'd5
   } fpc_phase_e;

   // rounds a time in ns up to whole clock cycles, never below one
   function automatic int ns_to_cyc(input int ns, input int period_ps);
      int c;
      c = (ns * 1000 + period_ps - 1) / period_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fpc_cmd_seq.sv
module fpc_cmd_seq
   import fpc_pkg::*;
#(
   parameter int AW = 18
) (
   input  fpc_op_e            op,
   input  logic [2:0]         step,
   input  logic [AW-1:0]      tgt_addr,
   input  logic [BYTE_W-1:0]  tgt_data,
   output logic [AW-1:0]      wr_addr,
   output logic [BYTE_W-1:0]  wr_data,
   output logic               last
);

   localparam logic [14:0] UNLK_HI = 15'h5555;
   localparam logic [14:0] UNLK_LO = 15'h2AAA;
   localparam logic [AW-1:0] A_HI = AW'(UNLK_HI);
   localparam logic [AW-1:0] A_LO = AW'(UNLK_LO);

   if (AW < 15) begin : g_aw_bad
      $error("fpc_cmd_seq: AW must be at least 15");
   end

   logic [AW-1:0]     a_tab [SEQ_MAX];
   logic [BYTE_W-1:0] d_tab [SEQ_MAX];

   for (genvar g = 0; g < SEQ_MAX; g++) begin : g_step
      if (g == 1 || g == 4) begin : g_lo
         assign a_tab[g] = A_LO;
         assign d_tab[g] = 8'h55;
      end else if (g == 2) begin : g_cmd
         assign a_tab[g] = A_HI;
         assign d_tab[g] = (op == OP_PROG) ? 8'hA0 : 8'h80;
      end else if (g == 3) begin : g_prog
         assign a_tab[g] = (op == OP_PROG) ? tgt_addr : A_HI;
         assign d_tab[g] = (op == OP_PROG) ? tgt_data : 8'hAA;
      end else if (g == 5) begin : g_erase
         assign a_tab[g] = (op == OP_SECT) ? tgt_addr : A_HI;
         assign d_tab[g] = (op == OP_SECT) ? 8'h30 : 8'h10;
      end else begin : g_hi
         assign a_tab[g] = A_HI;
         assign d_tab[g] = 8'hAA;
      end
   end

   assign wr_addr = a_tab[step];
   assign wr_data = d_tab[step];
   assign last    = (op == OP_PROG) ? (step == 3'd3) : (step == 3'd5);

endmodule

// File: rtl/fpc_bus_phy.sv
module fpc_bus_phy
   import fpc_pkg::*;
#(
   parameter int AW      = 18,
   parameter int LOW_CYC = 4,
   parameter int HIGH_CYC = 3,
   parameter int ACC_CYC = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_read,
   input  logic [AW-1:0]     addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              tog_in,
   output logic              done,
   output logic              rd_bit,
   output logic [AW-1:0]     flash_addr,
   output logic [BYTE_W-1:0] flash_dq_out,
   output logic              flash_dq_oe,
   output logic              flash_ce_n,
   output logic              flash_oe_n,
   output logic              flash_we_n
);

   localparam int MAXC = imax(imax(LOW_CYC, HIGH_CYC), ACC_CYC);
   localparam int CW   = $clog2(MAXC + 2);

   if (LOW_CYC < 1 || HIGH_CYC < 1 || ACC_CYC < 1) begin : g_cyc_bad
      $error("fpc_bus_phy: cycle counts must be positive");
   end

   fpc_phase_e       ph;
   logic [CW-1:0]    cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph           <= P_IDLE;
         cnt          <= '0;
         done         <= 1'b0;
         rd_bit       <= 1'b0;
         flash_addr   <= '0;
         flash_dq_out <= '0;
         flash_dq_oe  <= 1'b0;
         flash_ce_n   <= 1'b1;
         flash_oe_n   <= 1'b1;
         flash_we_n   <= 1'b1;
      end else begin
         done <= 1'b0;
         case (ph)
            P_IDLE: if (start) begin
               flash_addr <= addr;
               flash_ce_n <= 1'b0;
               cnt        <= '0;
               if (is_read) begin
                  flash_oe_n <= 1'b0;
                  ph         <= P_RACC;
               end else begin
                  flash_dq_out <= wdata;
                  flash_dq_oe  <= 1'b1;
                  ph           <= P_WSET;
               end
            end
            P_WSET: begin
               flash_we_n <= 1'b0;
               cnt        <= '0;
               ph         <= P_WLOW;
            end
            P_WLOW: begin
               if (cnt == CW'(LOW_CYC - 1)) begin
                  flash_we_n <= 1'b1;
                  cnt        <= '0;
                  ph         <= P_WHOLD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            P_WHOLD: begin
               if (cnt == CW'(HIGH_CYC - 1)) begin
                  flash_ce_n  <= 1'b1;
                  flash_dq_oe <= 1'b0;
                  done        <= 1'b1;
                  ph          <= P_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            P_RACC: begin
               if (cnt == CW'(ACC_CYC)) begin
                  rd_bit     <= tog_in;
                  flash_oe_n <= 1'b1;
                  flash_ce_n <= 1'b1;
                  ph         <= P_RGAP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            P_RGAP: begin
               done <= 1'b1;
               ph   <= P_IDLE;
            end
            default: ph <= P_IDLE;
         endcase
      end
   end

   // R6
   we_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_we_n |-> (!flash_ce_n && flash_oe_n && flash_dq_oe));

   // R7
   oe_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_oe_n |-> (flash_we_n && !flash_dq_oe && !flash_ce_n));

   // R6
   wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

endmodule

// File: rtl/fpc_poll_timer.sv
module fpc_poll_timer
   import fpc_pkg::*;
#(
   parameter int PROG_LIM  = 400,
   parameter int ERASE_LIM = 1500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic erase_mode,
   output logic expired
);

   localparam int MAXL = imax(PROG_LIM, ERASE_LIM);
   localparam int TW   = $clog2(MAXL + 2);

   if (PROG_LIM < 1 || ERASE_LIM < 1) begin : g_lim_bad
      $error("fpc_poll_timer: limits must be positive");
   end

   logic [TW-1:0] cnt;
   logic [TW-1:0] lim;

   assign lim     = erase_mode ? TW'(ERASE_LIM) : TW'(PROG_LIM);
   assign expired = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (run && (cnt != TW'(MAXL + 1))) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9
   expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && expired) |=> expired);

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import fpc_pkg::*;
#(
   parameter int AW                = 18,
   parameter int CLK_PERIOD_PS     = 10000,
   parameter int WE_LOW_NS         = 40,
   parameter int WE_HIGH_NS        = 30,
   parameter int DATA_SETUP_NS     = 30,
   parameter int ADDR_HOLD_NS      = 30,
   parameter int READ_ACCESS_NS    = 70,
   parameter int PROG_TIMEOUT_CYC  = 400,
   parameter int ERASE_TIMEOUT_CYC = 1500,
   parameter int CONFIRM_READS     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [AW-1:0]     req_addr,
   input  logic [BYTE_W-1:0] req_data,
   output logic              resp_valid,
   output logic              resp_err,
   output logic [AW-1:0]     flash_addr,
   output logic [BYTE_W-1:0] flash_dq_out,
   output logic              flash_dq_oe,
   input  logic              flash_tog_in,
   output logic              flash_ce_n,
   output logic              flash_oe_n,
   output logic              flash_we_n
);

   localparam int LOW_CYC  = imax(ns_to_cyc(WE_LOW_NS, CLK_PERIOD_PS),
                                  ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_PS));
   localparam int HIGH_CYC = imax(ns_to_cyc(WE_HIGH_NS, CLK_PERIOD_PS),
                                  ns_to_cyc(ADDR_HOLD_NS, CLK_PERIOD_PS));
   localparam int ACC_CYC  = ns_to_cyc(READ_ACCESS_NS, CLK_PERIOD_PS);
   localparam int RW       = (CONFIRM_READS < 1) ? 1 : $clog2(CONFIRM_READS + 1);

   if (CONFIRM_READS < 0) begin : g_conf_bad
      $error("flash_prog_ctrl: CONFIRM_READS must not be negative");
   end
   if (CLK_PERIOD_PS < 1) begin : g_clk_bad
      $error("flash_prog_ctrl: CLK_PERIOD_PS must be positive");
   end

   fpc_state_e        state;
   fpc_op_e           op_q;
   logic [AW-1:0]     addr_q;
   logic [BYTE_W-1:0] data_q;
   logic [2:0]        step_q;
   logic              prev_q;
   logic              have_prev;
   logic [RW-1:0]     run_q;

   logic [AW-1:0]     seq_addr;
   logic [BYTE_W-1:0] seq_data;
   logic              seq_last;
   logic              phy_start;
   logic              phy_is_read;
   logic              phy_done;
   logic              phy_bit;
   logic              tmr_expired;
   logic              tmr_clr;
   logic              tmr_run;

   assign req_ready   = (state == S_IDLE) && !resp_valid;
   assign phy_is_read = (state == S_RD);
   assign phy_start   = (state == S_WR) || ((state == S_RD) && !tmr_expired);
   assign tmr_clr     = (state == S_WR_WAIT);
   assign tmr_run     = (state == S_RD) || (state == S_RD_WAIT);

   fpc_cmd_seq #(.AW(AW)) u_seq (
      .op       (op_q),
      .step     (step_q),
      .tgt_addr (addr_q),
      .tgt_data (data_q),
      .wr_addr  (seq_addr),
      .wr_data  (seq_data),
      .last     (seq_last)
   );

   fpc_bus_phy #(
      .AW       (AW),
      .LOW_CYC  (LOW_CYC),
      .HIGH_CYC (HIGH_CYC),
      .ACC_CYC  (ACC_CYC)
   ) u_phy (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (phy_start),
      .is_read      (phy_is_read),
      .addr         (seq_addr),
      .wdata        (seq_data),
      .tog_in       (flash_tog_in),
      .done         (phy_done),
      .rd_bit       (phy_bit),
      .flash_addr   (flash_addr),
      .flash_dq_out (flash_dq_out),
      .flash_dq_oe  (flash_dq_oe),
      .flash_ce_n   (flash_ce_n),
      .flash_oe_n   (flash_oe_n),
      .flash_we_n   (flash_we_n)
   );

   fpc_poll_timer #(
      .PROG_LIM  (PROG_TIMEOUT_CYC),
      .ERASE_LIM (ERASE_TIMEOUT_CYC)
   ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (tmr_clr),
      .run        (tmr_run),
      .erase_mode (op_q != OP_PROG),
      .expired    (tmr_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         op_q       <= OP_PROG;
         addr_q     <= '0;
         data_q     <= '0;
         step_q     <= '0;
         prev_q     <= 1'b0;
         have_prev  <= 1'b0;
         run_q      <= '0;
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
      end else begin
         resp_valid <= 1'b0;
         case (state)
            S_IDLE: if (req_valid && req_ready) begin
               op_q   <= fpc_op_e'(req_op);
               addr_q <= req_addr;
               data_q <= req_data;
               step_q <= '0;
               if (fpc_op_e'(req_op) == OP_BAD) begin
                  resp_valid <= 1'b1;
                  resp_err   <= 1'b1;
               end else begin
                  state <= S_WR;
               end
            end
            S_WR: state <= S_WR_WAIT;
            S_WR_WAIT: if (phy_done) begin
               if (seq_last) begin
                  have_prev <= 1'b0;
                  run_q     <= '0;
                  state     <= S_RD;
               end else begin
                  step_q <= step_q + 1'b1;
                  state  <= S_WR;
               end
            end
            S_RD: begin
               if (tmr_expired) begin
                  resp_valid <= 1'b1;
                  resp_err   <= 1'b1;
                  state      <= S_IDLE;
               end else begin
                  state <= S_RD_WAIT;
               end
            end
            S_RD_WAIT: if (phy_done) begin
               state <= S_RD;
               if (!have_prev) begin
                  prev_q    <= phy_bit;
                  have_prev <= 1'b1;
               end else if (phy_bit == prev_q) begin
                  if (run_q == RW'(CONFIRM_READS)) begin
                     resp_valid <= 1'b1;
                     resp_err   <= 1'b0;
                     state      <= S_IDLE;
                  end else begin
                     run_q <= run_q + 1'b1;
                  end
               end else begin
                  run_q  <= '0;
                  prev_q <= phy_bit;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R10
   rdy_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> $past(resp_valid));

   // R10
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R5
   bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_op == 2'd3)) |=> (resp_valid && resp_err));

   // R9
   resp_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (flash_oe_n && flash_we_n && !flash_dq_oe));

endmodule

// File: tb/flash_prog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_prog_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [17:0] req_addr = '0;
   logic [7:0]  req_data = '0;
   logic        resp_valid;
   logic        resp_err;
   logic [17:0] flash_addr;
   logic [7:0]  flash_dq_out;
   logic        flash_dq_oe;
   logic        flash_tog_in;
   logic        flash_ce_n;
   logic        flash_oe_n;
   logic        flash_we_n;

   always #5 clk = ~clk;

   flash_prog_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_op       (req_op),
      .req_addr     (req_addr),
      .req_data     (req_data),
      .resp_valid   (resp_valid),
      .resp_err     (resp_err),
      .flash_addr   (flash_addr),
      .flash_dq_out (flash_dq_out),
      .flash_dq_oe  (flash_dq_oe),
      .flash_tog_in (flash_tog_in),
      .flash_ce_n   (flash_ce_n),
      .flash_oe_n   (flash_oe_n),
      .flash_we_n   (flash_we_n)
   );

   int n_checks = 0;
   int n_errs   = 0;
   bit finished = 1'b0;

   // flash model state
   int          mdl_busy  = 0;
   int          mdl_stall = 0;
   logic        mdl_tog   = 1'b1;
   logic        rd_valid  = 1'b0;
   int          nwr = 0;
   int          nrd = 0;
   logic [17:0] wa [8];
   logic [7:0]  wd [8];
   realtime     t_fall = 0.0;
   realtime     t_rise = 0.0;
   bit          seen_rise = 1'b0;
   int          low_viol = 0;
   int          gap_viol = 0;
   int          hold_viol = 0;

   assign flash_tog_in = rd_valid ? mdl_tog : 1'b1;

   always @(negedge flash_we_n) begin
      if (rst_n === 1'b1 && flash_ce_n === 1'b0) begin
         t_fall = $realtime;
         if (seen_rise && (t_fall - t_rise < 30.0)) gap_viol++;
      end
   end

   always @(posedge flash_we_n) begin
      if (rst_n === 1'b1 && flash_ce_n === 1'b0) begin
         t_rise = $realtime;
         seen_rise = 1'b1;
         if (t_rise - t_fall < 40.0) low_viol++;
         if (nwr < 8) begin
            wa[nwr] = flash_addr;
            wd[nwr] = flash_dq_out;
         end
         nwr++;
      end
   end

   always @(flash_addr or flash_dq_out) begin
      if (seen_rise && ($realtime - t_rise < 30.0)) hold_viol++;
   end

   always begin
      @(negedge flash_oe_n);
      rd_valid = 1'b0;
      #70;
      rd_valid = 1'b1;
   end

   always @(posedge flash_oe_n) begin
      if (rst_n === 1'b1) begin
         rd_valid = 1'b0;
         nrd++;
         if (mdl_busy > 0) begin
            mdl_busy--;
            if (nrd != mdl_stall) mdl_tog = ~mdl_tog;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [17:0] ex_addr(input int op, input int i, input logic [17:0] t);
      if (i == 1 || i == 4) return 18'h2AAA;
      if ((op == 0 && i == 3) || (op == 1 && i == 5)) return t;
      return 18'h5555;
   endfunction

   function automatic logic [7:0] ex_data(input int op, input int i, input logic [7:0] d);
      if (i == 1 || i == 4) return 8'h55;
      if (i == 2) return (op == 0) ? 8'hA0 : 8'h80;
      if (i == 3) return (op == 0) ? d : 8'hAA;
      if (i == 5) return (op == 1) ? 8'h30 : 8'h10;
      return 8'hAA;
   endfunction

   function automatic string op_tag(input int op);
      if (op == 0) return "R2";
      if (op == 1) return "R3";
      return "R4";
   endfunction

   task automatic finish_sim();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   endtask

   // exp_reads < 0: timeout expected, reads must stay below busy
   task automatic run_req(input int op, input logic [17:0] a, input logic [7:0] d,
                          input int busy, input int stall, input bit exp_err,
                          input int exp_reads, input string tag);
      int wait_cyc;
      int n_exp;
      wait_cyc = 0;
      @(negedge clk);
      while (!req_ready && wait_cyc < 100) begin
         @(negedge clk);
         wait_cyc++;
      end
      mdl_busy  = busy;
      mdl_stall = stall;
      mdl_tog   = 1'b1;
      nwr = 0;
      nrd = 0;
      req_op    = op[1:0];
      req_addr  = a;
      req_data  = d;
      req_valid = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b0, {"R10 ready low after accept ", tag}, req_ready, 0);
      if (op == 3) begin
         req_valid = 1'b0;
         check(resp_valid && resp_err, "R5 reject response", {resp_valid, resp_err}, 2'b11);
         repeat (3) @(negedge clk);
         check(nwr == 0 && flash_ce_n, "R5 no bus cycle", nwr, 0);
         return;
      end
      // R10: a different request held valid during the operation is ignored
      req_op   = 2'((op + 1) % 3);
      req_addr = ~a;
      for (int i = 0; i < 15; i++) @(negedge clk);
      req_valid = 1'b0;
      wait_cyc = 0;
      while (!resp_valid && wait_cyc < 30000) begin
         @(negedge clk);
         wait_cyc++;
      end
      check(resp_valid == 1'b1, {"R8 response seen ", tag}, resp_valid, 1);
      check(resp_err == exp_err, {"R9 error flag ", tag}, resp_err, exp_err);
      n_exp = (op == 0) ? 4 : 6;
      check(nwr == n_exp, {op_tag(op), " write count ", tag}, nwr, n_exp);
      for (int i = 0; i < n_exp && i < nwr; i++) begin
         check(wa[i] == ex_addr(op, i, a), {op_tag(op), " write address ", tag}, wa[i], ex_addr(op, i, a));
         check(wd[i] == ex_data(op, i, d), {op_tag(op), " write data ", tag}, wd[i], ex_data(op, i, d));
      end
      if (exp_reads >= 0)
         check(nrd == exp_reads, {"R8 read count at completion ", tag}, nrd, exp_reads);
      else
         check(nrd < busy, {"R9 aborted while busy ", tag}, nrd, busy);
      check(flash_ce_n && flash_oe_n && !flash_dq_oe, {"R9 bus released ", tag},
            {flash_ce_n, flash_oe_n, flash_dq_oe}, 3'b110);
      @(negedge clk);
      check(req_ready == 1'b1 && !resp_valid, {"R10 ready back ", tag}, req_ready, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
      check(resp_valid == 1'b0, "R1 no response", resp_valid, 0);
      check(flash_ce_n && flash_oe_n && flash_we_n, "R1 strobes high",
            {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
      check(flash_dq_oe == 1'b0, "R1 data not driven", flash_dq_oe, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // directed cases
      run_req(0, 18'h3FFFF, 8'h00, 6, 0, 1'b0, 10, "prog top");
      run_req(1, 18'h3F000, 8'h5A, 8, 0, 1'b0, 12, "sector");
      run_req(2, 18'h12345, 8'h77, 7, 0, 1'b0, 11, "chip");
      run_req(0, 18'h00100, 8'hC3, 10, 4, 1'b0, 14, "R8 race stall");
      run_req(3, 18'h00000, 8'h00, 5, 0, 1'b1, 0, "bad op");
      run_req(0, 18'h01234, 8'h9E, 60, 0, 1'b1, -1, "R9 prog timeout");
      run_req(1, 18'h21000, 8'h00, 60, 0, 1'b0, 64, "R9 erase long ok");
      run_req(2, 18'h00000, 8'h00, 160, 0, 1'b1, -1, "R9 erase timeout");

      // random cases
      for (int k = 0; k < 10; k++) begin
         int op;
         int busy;
         int stall;
         op    = int'($urandom % 3);
         busy  = 6 + int'($urandom % 10);
         stall = ($urandom % 2 == 1) ? 2 + int'($urandom % (busy - 3)) : 0;
         run_req(op, 18'($urandom), 8'($urandom), busy, stall, 1'b0, busy + 4, "random");
      end

      check(low_viol == 0, "R6 strobe low width", low_viol, 0);
      check(gap_viol == 0, "R6 strobe high gap", gap_viol, 0);
      check(hold_viol == 0, "R6 address/data hold", hold_viol, 0);
      finish_sim();
   end

endmodule